// File: doc/BRIEF.md
# Serial Input Interrupt Unit

This block raises interrupts for the inputs of a serial input array that is organised as a grid of ports by bit indices. When a burst of serial shifting finishes, the shifter pulses `burst_done` and presents every freshly captured input value on `burst_data`. Each input then goes through a detector that compares the new value with the value from the previous burst, or with a level polarity. The detector's trigger type is set per input. A hit makes the input's pending flag set, and the flag stays set until software acknowledges it.

Configuration uses a simple write strobe. Every register word covers one bit index and holds one bit per port. Each input has a 2-bit trigger type and a polarity bit, and it is gated by a per-input enable. The identity words report which enabled inputs are pending. A single interrupt line goes high when any identity bit is set and the master enable is on.

Top module: `sio_in_irq`

## Requirements
- R1: After reset, all pending flags, enables, trigger types, polarities, the master enable and the stored previous-burst values are zero, so `ident` and `irq` are low.
- R2: With trigger type 0 (level), a burst sets the pending flag of every input whose new value differs from its polarity bit. Polarity 0 means active high and polarity 1 means active low.
- R3: In level mode, an acknowledged input that is still at its active level becomes pending again on the next burst.
- R4: With trigger type 1, a burst sets the pending flag of every input whose new value differs from its value in the previous burst.
- R5: With trigger type 2, a burst sets the pending flag of every input that was 1 in the previous burst and is 0 in the new one.
- R6: With trigger type 3, a burst sets the pending flag of every input that was 0 before and is 1 now. The type's low bit is held in trigger word b and its high bit in trigger word NBIT+b, both at the input's port position.
- R7: The polarity bit has no effect in trigger types 1 to 3.
- R8: Writing kind 3 (acknowledge) to word b clears the pending flag of each port whose data bit is 1. Ports written with 0 keep their flag.
- R9: When an input's event and its acknowledge arrive in the same cycle, the pending flag stays set.
- R10: Bit p of identity word b equals the pending flag of input (b,p) ANDed with its enable bit. Pending flags are recorded while the input is disabled, so they appear as soon as the input is enabled.
- R11: `irq` is high exactly when the master enable is on and at least one identity bit is set.
- R12: Changes on `burst_data` without `burst_done` have no effect, and no pending flag is set between bursts.
- R13: The write kinds are 0 trigger (word index 0 to 2*NBIT-1), 1 polarity, 2 enable, 3 acknowledge and 4 master enable (data bit 0). Kinds 5 to 7, and polarity, enable or acknowledge writes to an index of NBIT or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_done | input | 1 | One-cycle strobe: a new burst has been captured |
| burst_data | input | NBIT*NPORT | Captured inputs, bit b*NPORT+p is input (b,p) |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 3 | Register kind of the write |
| cfg_idx | input | clog2(2*NBIT) | Word (bit index) of the write |
| cfg_wdata | input | NPORT | Write data, one bit per port |
| ident | output | NBIT*NPORT | Identity words, same layout as burst_data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NPORT=4 and NBIT=2. That gives eight inputs, so every possible burst word (256 values) can be swept in sequence for each trigger type and polarity. Each step compares the result with a model that works from the previous-value history. The small size also puts the high trigger half at word 2+b, which tests the split type encoding with a mix of types across ports. It brings the same-cycle event/acknowledge race and the disabled-but-pending case into direct reach.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam logic [2:0] K_TRIG   = 3'd0;
  localparam logic [2:0] K_POL    = 3'd1;
  localparam logic [2:0] K_EN     = 3'd2;
  localparam logic [2:0] K_ACK    = 3'd3;
  localparam logic [2:0] K_MASTER = 3'd4;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_BOTH  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_RISE  = 2'd3
  } trig_e;

  // Event decision for one input given its type, polarity and history.
  function automatic logic trig_hit(input trig_e t, input logic pol,
                                    input logic prv, input logic cur);
    logic r;
    case (t)
      TRG_LEVEL: r = cur ^ pol;
      TRG_BOTH:  r = cur ^ prv;
      TRG_FALL:  r = prv & ~cur;
      default:   r = ~prv & cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sio_irq_cfg.sv
module sio_irq_cfg
  import sio_irq_pkg::*;
#(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int W    = NPORT * NBIT,
  localparam int IDXW = $clog2(2 * NBIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      kind,
  input  logic [IDXW-1:0] idx,
  input  logic [NPORT-1:0] wdata,
  output logic [W-1:0]    trig_lo,
  output logic [W-1:0]    trig_hi,
  output logic [W-1:0]    pol,
  output logic [W-1:0]    en,
  output logic [W-1:0]    ack_mask,
  output logic            master
);

  for (genvar b = 0; b < NBIT; b++) begin : g_word
    localparam logic [IDXW-1:0] LO_I = IDXW'(b);
    localparam logic [IDXW-1:0] HI_I = IDXW'(NBIT + b);

    logic sel_lo, sel_hi, sel_pol, sel_en, sel_ack;
    assign sel_lo  = we && (kind == K_TRIG) && (idx == LO_I);
    assign sel_hi  = we && (kind == K_TRIG) && (idx == HI_I);
    assign sel_pol = we && (kind == K_POL)  && (idx == LO_I);
    assign sel_en  = we && (kind == K_EN)   && (idx == LO_I);
    assign sel_ack = we && (kind == K_ACK)  && (idx == LO_I);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_lo[b*NPORT +: NPORT] <= '0;
        trig_hi[b*NPORT +: NPORT] <= '0;
        pol[b*NPORT +: NPORT]     <= '0;
        en[b*NPORT +: NPORT]      <= '0;
      end else begin
        if (sel_lo)  trig_lo[b*NPORT +: NPORT] <= wdata;
        if (sel_hi)  trig_hi[b*NPORT +: NPORT] <= wdata;
        if (sel_pol) pol[b*NPORT +: NPORT]     <= wdata;
        if (sel_en)  en[b*NPORT +: NPORT]      <= wdata;
      end
    end

    assign ack_mask[b*NPORT +: NPORT] = sel_ack ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      master <= 1'b0;
    else if (we && kind == K_MASTER)
      master <= wdata[0];
  end

endmodule

// File: rtl/sio_irq_detect.sv
module sio_irq_detect
  import sio_irq_pkg::*;
#(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int W    = NPORT * NBIT
) (
  input  logic [W-1:0] trig_lo,
  input  logic [W-1:0] trig_hi,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] cur,
  output logic [W-1:0] evt
);

  for (genvar i = 0; i < W; i++) begin : g_in
    trig_e t;
    assign t      = trig_e'({trig_hi[i], trig_lo[i]});
    assign evt[i] = trig_hit(t, pol[i], prev[i], cur[i]);
  end

endmodule

// File: rtl/sio_irq_pend.sv
module sio_irq_pend #(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int W    = NPORT * NBIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack_mask,
  output logic [W-1:0] prev,
  output logic [W-1:0] evt_hit,
  output logic [W-1:0] pend
);

  assign evt_hit = evt & {W{strobe}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      prev <= '0;
    end else begin
      pend <= (pend & ~ack_mask) | evt_hit;
      if (strobe) prev <= cur;
    end
  end

endmodule

// File: rtl/sio_in_irq.sv
module sio_in_irq #(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int W    = NPORT * NBIT,
  localparam int IDXW = $clog2(2 * NBIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_done,
  input  logic [W-1:0]     burst_data,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_kind,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [NPORT-1:0] cfg_wdata,
  output logic [W-1:0]     ident,
  output logic             irq
);

  logic [W-1:0] trig_lo, trig_hi, pol, en, ack_mask;
  logic [W-1:0] prev, evt, evt_hit, pend;
  logic         master;

  sio_irq_cfg #(.NPORT(NPORT), .NBIT(NBIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
    .wdata(cfg_wdata), .trig_lo(trig_lo), .trig_hi(trig_hi), .pol(pol),
    .en(en), .ack_mask(ack_mask), .master(master)
  );

  sio_irq_detect #(.NPORT(NPORT), .NBIT(NBIT)) u_det (
    .trig_lo(trig_lo), .trig_hi(trig_hi), .pol(pol), .prev(prev),
    .cur(burst_data), .evt(evt)
  );

  sio_irq_pend #(.NPORT(NPORT), .NBIT(NBIT)) u_pend (
    .clk(clk), .rst_n(rst_n), .strobe(burst_done), .cur(burst_data),
    .evt(evt), .ack_mask(ack_mask), .prev(prev), .evt_hit(evt_hit),
    .pend(pend)
  );

  assign ident = pend & en;
  assign irq   = master & (|ident);

endmodule

// File: rtl/sio_in_irq_chk.sv
module sio_in_irq_chk #(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int W    = NPORT * NBIT
) (
  input logic         clk,
  input logic         rst_n,
  input logic         burst_done,
  input logic [W-1:0] ack_mask,
  input logic [W-1:0] evt_hit,
  input logic [W-1:0] pend,
  input logic [W-1:0] ident,
  input logic         master,
  input logic         irq
);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_mask) && !burst_done) |=> ((pend & $past(ack_mask)) == '0));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_hit) |=> ((pend & $past(evt_hit)) == $past(evt_hit)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_done && !(|ack_mask)) |=> $stable(pend));

  p_ident_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ident & ~pend) == '0));

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !irq);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ident));

endmodule

bind sio_in_irq sio_in_irq_chk #(.NPORT(NPORT), .NBIT(NBIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_done(burst_done), .ack_mask(ack_mask),
  .evt_hit(evt_hit), .pend(pend), .ident(ident), .master(master), .irq(irq)
);

// File: tb/sio_in_irq_test.sv
module sio_in_irq_test;
  localparam int NP = 4;
  localparam int NB = 2;
  localparam int W  = NP * NB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          burst_done;
  logic [W-1:0]  burst_data;
  logic          cfg_we;
  logic [2:0]    cfg_kind;
  logic [1:0]    cfg_idx;
  logic [NP-1:0] cfg_wdata;
  logic [W-1:0]  ident;
  logic          irq;

  sio_in_irq #(.NPORT(NP), .NBIT(NB)) uut (
    .clk(clk), .rst_n(rst_n), .burst_done(burst_done), .burst_data(burst_data),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .ident(ident), .irq(irq)
  );

  int runs = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_lo, m_hi, m_pol, m_en, m_pend, m_prev;
  logic         m_mst;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] e;
    e = m_pend & m_en;
    chk(tag, ident, e);
    chk(tag, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, (m_mst && e != 0)});
  endtask

  function automatic logic [W-1:0] ack_of(input int idx, input logic [NP-1:0] d);
    logic [W-1:0] m = '0;
    if (idx < NB) m[idx*NP +: NP] = d;
    return m;
  endfunction

  task automatic model_write(input int kind, input int idx, input logic [NP-1:0] d);
    case (kind)
      0: if (idx < NB) m_lo[idx*NP +: NP] = d;
         else if (idx < 2*NB) m_hi[(idx-NB)*NP +: NP] = d;
      1: if (idx < NB) m_pol[idx*NP +: NP] = d;
      2: if (idx < NB) m_en[idx*NP +: NP] = d;
      3: m_pend = m_pend & ~ack_of(idx, d);
      4: m_mst = d[0];
      default: ;
    endcase
  endtask

  task automatic wr(input int kind, input int idx, input logic [NP-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 2'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(kind, idx, d);
  endtask

  function automatic logic [W-1:0] model_evt(input logic [W-1:0] d);
    logic [W-1:0] e;
    for (int i = 0; i < W; i++) begin
      int t;
      t = 2 * int'(m_hi[i]) + int'(m_lo[i]);
      if (t == 0)      e[i] = (d[i] != m_pol[i]);
      else if (t == 1) e[i] = (d[i] != m_prev[i]);
      else if (t == 2) e[i] = (int'(m_prev[i]) > int'(d[i]));
      else             e[i] = (int'(d[i]) > int'(m_prev[i]));
    end
    return e;
  endfunction

  task automatic burst(input logic [W-1:0] d, input bit do_ack,
                       input int aidx, input logic [NP-1:0] ad);
    logic [W-1:0] am;
    @(negedge clk);
    burst_done = 1'b1; burst_data = d;
    if (do_ack) begin
      cfg_we = 1'b1; cfg_kind = 3'd3; cfg_idx = 2'(aidx); cfg_wdata = ad;
    end
    @(negedge clk);
    burst_done = 1'b0; cfg_we = 1'b0;
    am = do_ack ? ack_of(aidx, ad) : '0;
    m_pend = model_evt(d) | (m_pend & ~am);
    m_prev = d;
  endtask

  task automatic ack_all();
    for (int b = 0; b < NB; b++) wr(3, b, '1);
  endtask

  task automatic set_type(input int t, input logic p);
    for (int b = 0; b < NB; b++) begin
      wr(0, b, t[0] ? '1 : '0);
      wr(0, NB + b, t[1] ? '1 : '0);
      wr(1, b, p ? '1 : '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    string tags[4];
    tags[0] = "R2"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";
    rst_n = 1'b0; burst_done = 1'b0; burst_data = '0;
    cfg_we = 1'b0; cfg_kind = '0; cfg_idx = '0; cfg_wdata = '0;
    m_lo = '0; m_hi = '0; m_pol = '0; m_en = '0; m_pend = '0; m_prev = '0; m_mst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // Level, active high, all zero after reset: no event
    wr(2, 0, '1); wr(2, 1, '1); wr(4, 0, 4'h1);
    burst('0, 0, 0, '0);
    check_all("R1");

    // Exhaustive burst sweeps for each type and polarity
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 2; p++) begin
        set_type(t, p[0]);
        ack_all();
        for (int k = 0; k < 256; k++) begin
          burst(W'(k), 0, 0, '0);
          check_all((t != 0 && p == 1) ? "R7" : tags[t]);
          if (k % 4 == 3) ack_all();
        end
      end
    end

    // R3: level re-pend after acknowledge
    set_type(0, 1'b0); ack_all();
    burst('1, 0, 0, '0); check_all("R3");
    ack_all(); check_all("R8");
    chk("R8", ident, '0);
    burst('1, 0, 0, '0); check_all("R3");
    chk("R3", ident, '1);

    // R8: acknowledge with partial mask
    wr(3, 0, 4'b0101); check_all("R8");
    chk("R8", ident, 8'hFA);

    // R9: event and acknowledge in the same cycle (level active)
    burst('1, 1, 1, 4'hF); check_all("R9");
    chk("R9", ident, '1);

    // R10: pending recorded while disabled
    ack_all();
    wr(2, 0, '0); wr(2, 1, '0);
    burst(8'h3C, 0, 0, '0); check_all("R10");
    chk("R10", ident, '0);
    wr(2, 0, 4'hF); wr(2, 1, 4'hF); check_all("R10");
    chk("R10", ident, 8'h3C);

    // R11: master gate
    wr(4, 0, 4'h0); check_all("R11");
    chk("R11", {7'b0, irq}, 8'h00);
    wr(4, 0, 4'h1); check_all("R11");
    chk("R11", {7'b0, irq}, 8'h01);

    // R12: data changes without strobe
    set_type(1, 1'b0); ack_all();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); burst_data = W'(k * 29);
    end
    @(negedge clk);
    check_all("R12"); chk("R12", ident, '0);

    // R13: unused kinds and out-of-range indices
    ack_all();
    wr(5, 0, 4'hF); wr(7, 1, 4'hF); wr(1, 2, 4'hF); wr(2, 3, 4'h0);
    set_type(0, 1'b0); ack_all();
    burst(8'h81, 0, 0, '0); check_all("R13");
    chk("R13", ident, 8'h81);

    // R6: mixed per-port types via split low/high words
    ack_all();
    for (int b = 0; b < NB; b++) begin
      wr(0, b, 4'b1010); wr(0, NB + b, 4'b1100); wr(1, b, 4'b0000);
    end
    ack_all();
    for (int k = 0; k < 256; k++) begin
      burst(W'(k ^ (k >> 1)), 0, 0, '0);
      check_all("R6");
      ack_all();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule